// File: doc/BRIEF.md
# Stack Bytecode Execution Core

This block runs a short program of byte-wide stack-machine opcodes held in an external code memory. It reads one code byte per cycle through an address/data port. The memory is read combinationally, so the byte for the current address is valid in the same cycle. The core keeps a 32-bit operand stack and four 32-bit local-variable slots. It can push small constants and sign-extended byte immediates, move values between the stack and the slots, and add the two topmost values. A return opcode halts it.

A pulse on `start` restarts execution at code address 0 with an empty operand stack. The slots keep their values until reset. When the program returns, `done` rises and stays high. An illegal stack access or an unknown opcode raises `error` instead, and the core stops with its state frozen. A debug read port lets the surrounding logic or a test harness read any slot at any time.

Top module: `stack_bc_core`

## Requirements
- R1: After a synchronous active-low reset, `done` and `error` are 0, `code_addr` is 0, every slot reads 0, and nothing executes until `start`.
- R2: `start`, sampled high at a clock edge in any state, empties the operand stack and resumes fetching at address 0 on the next cycle; it does not alter the slots.
- R3: Opcode 0x10 pushes the following code byte, sign-extended to 32 bits. It spends two cycles, and `code_addr` advances by one in each of them.
- R4: Opcodes 0x02 to 0x08 push the constants -1 to 5 in that order.
- R5: Opcodes 0x3b to 0x3e pop the top value into slot 0 to 3. Opcodes 0x1a to 0x1d push the value of slot 0 to 3.
- R6: Opcode 0x60 replaces the two top stack entries with their sum modulo 2^32.
- R7: The operand stack holds DEPTH entries. Any push onto a full stack, any pop from an empty one, or an add with fewer than two entries raises `error` and leaves the stack unchanged.
- R8: Any opcode not listed in R3 to R6 or R9 raises `error`. Once `error` is high, no slot changes, `code_addr` holds, and `error` stays high until `start` or reset.
- R9: Opcode 0xb1 halts execution. `done` rises in the cycle after it executes and stays high, with `code_addr` frozen, until `start` or reset.
- R10: Every instruction takes one cycle, except 0x10, which takes two. `done` or `error` therefore appears exactly N cycles after the start cycle, where N is the sum of the cycle counts of the instructions executed.
- R11: `dbg_data` shows the slot selected by `dbg_slot` combinationally, and the slots keep their contents across `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Restart execution at address 0 with an empty stack |
| code_addr | output | ADDR_W | Code memory read address (program counter) |
| code_data | input | 8 | Code byte at `code_addr`, valid in the same cycle |
| done | output | 1 | Program returned; sticky |
| error | output | 1 | Stack fault or unknown opcode; sticky |
| dbg_slot | input | 2 | Slot selected for debug read |
| dbg_data | output | 32 | Value of the selected slot |

## Verification
The bench builds the core with DEPTH = 4 and ADDR_W = 8. A stack of four entries lets a program of a few bytes fill the stack exactly, which should succeed. Short programs then push one entry too many through each of the three push kinds: constant, byte immediate and slot load. These reach the overflow boundary of R7 without long instruction streams. Underflow is driven through a slot store and through an add with only one stack entry. A restart in mid-program with three entries still on the stack is set up so that a stack that failed to empty would overflow.

// File: rtl/stk_pkg.sv
// Package: shared widths, opcode values and type definitions for the
// stack bytecode core. Assumes 32-bit stack words and four local slots.
package stk_pkg;
    localparam int WORD_W = 32;
    localparam int NSLOT  = 4;
    localparam int SLOT_W = 2;

    localparam logic [7:0] OP_CONST_LO = 8'h02;
    localparam logic [7:0] OP_CONST_HI = 8'h08;
    localparam logic [7:0] OP_PUSHB    = 8'h10;
    localparam logic [7:0] OP_LOAD_LO  = 8'h1a;
    localparam logic [7:0] OP_LOAD_HI  = 8'h1d;
    localparam logic [7:0] OP_STORE_LO = 8'h3b;
    localparam logic [7:0] OP_STORE_HI = 8'h3e;
    localparam logic [7:0] OP_ADD      = 8'h60;
    localparam logic [7:0] OP_RET      = 8'hb1;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_IMM, ST_HALT, ST_FAULT
    } core_state_t;

    typedef enum logic [1:0] {
        SK_NONE, SK_PUSH, SK_POP, SK_ADD
    } stk_op_t;

    typedef enum logic [2:0] {
        K_CONST, K_PUSHB, K_LOAD, K_STORE, K_ADD, K_RET, K_BAD
    } op_kind_t;

    typedef struct packed {
        op_kind_t            kind;
        logic [SLOT_W-1:0]   slot;
        logic [WORD_W-1:0]   cval;
    } dec_t;
endpackage

// File: rtl/bc_decode.sv
// Module: bc_decode
// Classifies one opcode byte. Derives the slot index from the opcode for
// load and store, and the constant value for the small-constant group.
// Purely combinational; assumes nothing about the state of the core.
module bc_decode
    import stk_pkg::*;
(
    input  logic [7:0] op,
    output dec_t       dec
);
    // Map the opcode byte onto its instruction kind and embedded operand.
    always_comb begin
        dec.kind = K_BAD;
        dec.slot = '0;
        dec.cval = '0;
        if (op >= OP_CONST_LO && op <= OP_CONST_HI) begin
            dec.kind = K_CONST;
            dec.cval = WORD_W'(op) - WORD_W'(3);
        end else if (op >= OP_LOAD_LO && op <= OP_LOAD_HI) begin
            dec.kind = K_LOAD;
            dec.slot = SLOT_W'(op - OP_LOAD_LO);
        end else if (op >= OP_STORE_LO && op <= OP_STORE_HI) begin
            dec.kind = K_STORE;
            dec.slot = SLOT_W'(op - OP_STORE_LO);
        end else if (op == OP_PUSHB) begin
            dec.kind = K_PUSHB;
        end else if (op == OP_ADD) begin
            dec.kind = K_ADD;
        end else if (op == OP_RET) begin
            dec.kind = K_RET;
        end
    end
endmodule

// File: rtl/bc_opstack.sv
// Module: bc_opstack
// Operand stack of DEPTH words with a fill counter. Supports push, pop and
// an in-place add of the two top entries. Assumes the caller never issues
// an operation the current fill level cannot support (checked below).
module bc_opstack
    import stk_pkg::*;
#(
    parameter int DEPTH = 8
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  stk_op_t           op,
    input  logic [WORD_W-1:0] push_val,
    output logic [WORD_W-1:0] top,
    output logic [WORD_W-1:0] nxt,
    output logic [$clog2(DEPTH+1)-1:0] cnt
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = $clog2(DEPTH);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [IDX_W-1:0]  top_idx, nxt_idx, put_idx;

    assign put_idx = IDX_W'(cnt);
    assign top_idx = IDX_W'(cnt - CNT_W'(1));
    assign nxt_idx = IDX_W'(cnt - CNT_W'(2));
    assign top     = mem[top_idx];
    assign nxt     = mem[nxt_idx];

    // Track how many entries are live.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else begin
            unique case (op)
                SK_PUSH: cnt <= cnt + CNT_W'(1);
                SK_POP,
                SK_ADD:  cnt <= cnt - CNT_W'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    // Write pushed values and add results into the storage words.
    always_ff @(posedge clk) begin
        if (rst_n && !clear) begin
            if (op == SK_PUSH) mem[put_idx] <= push_val;
            else if (op == SK_ADD) mem[nxt_idx] <= top + nxt;
        end
    end

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (op == SK_PUSH) |-> (cnt < CNT_W'(DEPTH)));
    a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (op == SK_POP) |-> (cnt != '0));
    a_r6_add_operands: assert property (@(posedge clk) disable iff (!rst_n)
        (op == SK_ADD) |-> (cnt >= CNT_W'(2)));
    a_r6_add_result: assert property (@(posedge clk) disable iff (!rst_n)
        (op == SK_ADD && !clear) |=> (top == $past(top) + $past(nxt)));
endmodule

// File: rtl/bc_locals.sv
// Module: bc_locals
// Array of NSLOT local-variable words, one write port from the core, one
// read port for loads and one read port for debug. Reset clears all slots.
module bc_locals
    import stk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [WORD_W-1:0] rd_data,
    input  logic [SLOT_W-1:0] dbg_slot,
    output logic [WORD_W-1:0] dbg_data
);
    logic [WORD_W-1:0] slot_q [NSLOT];

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        // Hold one slot; load it when the core stores to its index.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q[s] <= '0;
            else if (wr_en && wr_slot == SLOT_W'(s))
                slot_q[s] <= wr_data;
        end

        a_r5_slot_written: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_slot == SLOT_W'(s)) |=> (slot_q[s] == $past(wr_data)));
        a_r11_slot_kept: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_slot == SLOT_W'(s)) |=> $stable(slot_q[s]));
    end

    assign rd_data  = slot_q[rd_slot];
    assign dbg_data = slot_q[dbg_slot];
endmodule

// File: rtl/bc_control.sv
// Module: bc_control
// Fetch/execute sequencer. Holds the program counter and the run state,
// decodes the byte at the counter and drives the stack and slot ports.
// Assumes the code byte is valid in the same cycle as its address.
module bc_control
    import stk_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DEPTH  = 8
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic [ADDR_W-1:0] pc,
    input  logic [7:0]        code_data,
    input  dec_t              dec,
    input  logic [$clog2(DEPTH+1)-1:0] stk_cnt,
    output stk_op_t           stk_op,
    output logic [WORD_W-1:0] push_val,
    output logic              stk_clear,
    input  logic [WORD_W-1:0] loc_rd,
    output logic              loc_we,
    output logic              done,
    output logic              error
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    core_state_t       state, state_n;
    logic [ADDR_W-1:0] pc_n;
    logic              full, empty, two;

    assign full      = (stk_cnt == CNT_W'(DEPTH));
    assign empty     = (stk_cnt == '0);
    assign two       = (stk_cnt >= CNT_W'(2));
    assign stk_clear = start;

    // Choose the next state, counter and stack/slot action for this cycle.
    always_comb begin
        state_n  = state;
        pc_n     = pc;
        stk_op   = SK_NONE;
        push_val = '0;
        loc_we   = 1'b0;
        if (start) begin
            state_n = ST_FETCH;
            pc_n    = '0;
        end else begin
            unique case (state)
                ST_FETCH: begin
                    unique case (dec.kind)
                        K_CONST: if (full) state_n = ST_FAULT;
                                 else begin
                                     stk_op   = SK_PUSH;
                                     push_val = dec.cval;
                                     pc_n     = pc + ADDR_W'(1);
                                 end
                        K_PUSHB: if (full) state_n = ST_FAULT;
                                 else begin
                                     state_n = ST_IMM;
                                     pc_n    = pc + ADDR_W'(1);
                                 end
                        K_LOAD:  if (full) state_n = ST_FAULT;
                                 else begin
                                     stk_op   = SK_PUSH;
                                     push_val = loc_rd;
                                     pc_n     = pc + ADDR_W'(1);
                                 end
                        K_STORE: if (empty) state_n = ST_FAULT;
                                 else begin
                                     stk_op = SK_POP;
                                     loc_we = 1'b1;
                                     pc_n   = pc + ADDR_W'(1);
                                 end
                        K_ADD:   if (!two) state_n = ST_FAULT;
                                 else begin
                                     stk_op = SK_ADD;
                                     pc_n   = pc + ADDR_W'(1);
                                 end
                        K_RET:   state_n = ST_HALT;
                        default: state_n = ST_FAULT;
                    endcase
                end
                ST_IMM: begin
                    stk_op   = SK_PUSH;
                    push_val = {{(WORD_W-8){code_data[7]}}, code_data};
                    pc_n     = pc + ADDR_W'(1);
                    state_n  = ST_FETCH;
                end
                default: ;
            endcase
        end
    end

    // Register the run state and program counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            pc    <= '0;
        end else begin
            state <= state_n;
            pc    <= pc_n;
        end
    end

    assign done  = (state == ST_HALT);
    assign error = (state == ST_FAULT);

    a_r2_start_entry: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (state == ST_FETCH && pc == '0));
    a_r3_imm_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IMM && !start) |=> (state == ST_FETCH && pc == $past(pc) + ADDR_W'(1)));
    a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(pc)));
    a_r8_fault_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (error && !start) |=> (error && $stable(pc)));
    a_r8_quiet_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (done || error || state == ST_IDLE) |-> (!loc_we && stk_op == SK_NONE));
    a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));
endmodule

// File: rtl/stack_bc_core.sv
// Module: stack_bc_core (top)
// Stack bytecode core: sequencer, opcode decoder, operand stack and local
// slot array. Assumes a code memory with a combinational byte read.
module stack_bc_core
    import stk_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DEPTH  = 8
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic [ADDR_W-1:0] code_addr,
    input  logic [7:0]        code_data,
    output logic              done,
    output logic              error,
    input  logic [SLOT_W-1:0] dbg_slot,
    output logic [WORD_W-1:0] dbg_data
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    dec_t              dec;
    stk_op_t           stk_op;
    logic [WORD_W-1:0] push_val, stk_top, stk_nxt, loc_rd;
    logic [CNT_W-1:0]  stk_cnt;
    logic              stk_clear, loc_we;

    bc_decode u_dec (
        .op  (code_data),
        .dec (dec)
    );

    bc_control #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .pc        (code_addr),
        .code_data (code_data),
        .dec       (dec),
        .stk_cnt   (stk_cnt),
        .stk_op    (stk_op),
        .push_val  (push_val),
        .stk_clear (stk_clear),
        .loc_rd    (loc_rd),
        .loc_we    (loc_we),
        .done      (done),
        .error     (error)
    );

    bc_opstack #(.DEPTH(DEPTH)) u_stk (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (stk_clear),
        .op       (stk_op),
        .push_val (push_val),
        .top      (stk_top),
        .nxt      (stk_nxt),
        .cnt      (stk_cnt)
    );

    bc_locals u_loc (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (loc_we),
        .wr_slot  (dec.slot),
        .wr_data  (stk_top),
        .rd_slot  (dec.slot),
        .rd_data  (loc_rd),
        .dbg_slot (dbg_slot),
        .dbg_data (dbg_data)
    );

    logic unused_nxt;
    assign unused_nxt = ^stk_nxt;
endmodule

// File: tb/stack_bc_core_tb.sv
`timescale 1ns/1ps
module stack_bc_core_tb;
    localparam int ADDR_W = 8;
    localparam int DEPTH  = 4;

    typedef struct packed {
        logic [127:0] prog;
        logic         exp_done;
        logic         exp_err;
        logic [7:0]   cyc;
        logic [31:0]  s0, s1, s2, s3;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        // R5 R6 R3: main sequence
        '{128'h100f3c10_093d033e_1b1c603e_b1000000, 1'b1, 1'b0, 8'd13, 32'd0, 32'd15, 32'd9, 32'd24},
        // R3 negative immediate, R6 mixed-sign add
        '{128'h10f63b10_053c1a1b_603db100_00000000, 1'b1, 1'b0, 8'd11, 32'hfffffff6, 32'd5, 32'hfffffffb, 32'd0},
        // R4 constants -1, 5, 4
        '{128'h0208603e_073bb100_00000000_00000000, 1'b1, 1'b0, 8'd7, 32'd4, 32'd0, 32'd0, 32'd4},
        // R3 R6 extreme byte values
        '{128'h1080107f_603db100_00000000_00000000, 1'b1, 1'b0, 8'd7, 32'd0, 32'd0, 32'hffffffff, 32'd0},
        // R7 stack filled exactly to DEPTH
        '{128'h10011002_10031004_6060603b_b1000000, 1'b1, 1'b0, 8'd13, 32'd10, 32'd0, 32'd0, 32'd0},
        // R7 constant push onto full stack
        '{128'h03030303_04b10000_00000000_00000000, 1'b0, 1'b1, 8'd5, 32'd0, 32'd0, 32'd0, 32'd0},
        // R7 store from empty stack
        '{128'h3c000000_00000000_00000000_00000000, 1'b0, 1'b1, 8'd1, 32'd0, 32'd0, 32'd0, 32'd0},
        // R7 add with one entry, R8 later store suppressed
        '{128'h10073b03_603cb100_00000000_00000000, 1'b0, 1'b1, 8'd5, 32'd7, 32'd0, 32'd0, 32'd0},
        // R8 unknown opcode stops execution
        '{128'h043dff3e_b1000000_00000000_00000000, 1'b0, 1'b1, 8'd3, 32'd0, 32'd0, 32'd1, 32'd0},
        // R7 byte push onto full stack
        '{128'h03030303_10050000_00000000_00000000, 1'b0, 1'b1, 8'd5, 32'd0, 32'd0, 32'd0, 32'd0},
        // R7 slot load onto full stack
        '{128'h03030303_1a000000_00000000_00000000, 1'b0, 1'b1, 8'd5, 32'd0, 32'd0, 32'd0, 32'd0}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] code_addr;
    logic [7:0]        code_data;
    logic              done, error;
    logic [1:0]        dbg_slot = '0;
    logic [31:0]       dbg_data;
    logic [7:0]        cmem [256];

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;
    assign code_data = cmem[code_addr];

    stack_bc_core #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .code_addr(code_addr),
        .code_data(code_data), .done(done), .error(error),
        .dbg_slot(dbg_slot), .dbg_data(dbg_data)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic load_prog(input logic [127:0] p);
        for (int i = 0; i < 256; i++) cmem[i] = 8'h00;
        for (int i = 0; i < 16; i++) cmem[i] = p[127-8*i -: 8];
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic run(output int n);
        n = 0;
        while (!(done || error) && n < 200) begin
            @(negedge clk);
            n++;
        end
    endtask

    function automatic logic [31:0] slot_exp(input vec_t v, input int s);
        case (s)
            0: return v.s0;
            1: return v.s1;
            2: return v.s2;
            default: return v.s3;
        endcase
    endfunction

    task automatic read_slot(input int s, output logic [31:0] v);
        dbg_slot = 2'(s);
        #1 v = dbg_data;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int          n;
        logic [31:0] v;
        logic [ADDR_W-1:0] a0;

        load_prog(128'h0);
        do_reset();
        // R1 reset state
        @(negedge clk);
        chk("R1", "done", 32'(done), 0);
        chk("R1", "error", 32'(error), 0);
        chk("R1", "code_addr", 32'(code_addr), 0);
        for (int s = 0; s < 4; s++) begin
            read_slot(s, v);
            chk("R1", "slot", v, 0);
        end
        repeat (3) @(negedge clk);
        chk("R1", "idle without start", 32'(done || error), 0);

        // Table of programs
        for (int k = 0; k < NV; k++) begin
            do_reset();
            load_prog(VECS[k].prog);
            pulse_start();
            run(n);
            chk("R9", "done flag", 32'(done), 32'(VECS[k].exp_done));
            chk("R8", "error flag", 32'(error), 32'(VECS[k].exp_err));
            chk("R10", "cycles", 32'(n), 32'(VECS[k].cyc));
            for (int s = 0; s < 4; s++) begin
                read_slot(s, v);
                chk("R5", "slot value", v, slot_exp(VECS[k], s));
            end
        end

        // R9 done stays high and code_addr holds
        do_reset();
        load_prog(128'h10053cb1_00000000_00000000_00000000);
        pulse_start();
        run(n);
        a0 = code_addr;
        repeat (4) @(negedge clk);
        chk("R9", "done sticky", 32'(done), 1);
        chk("R9", "addr frozen", 32'(code_addr), 32'(a0));

        // R11 slots survive a restart; R5 load then store
        load_prog(128'h1b3db100_00000000_00000000_00000000);
        pulse_start();
        chk("R2", "done cleared by start", 32'(done), 0);
        run(n);
        read_slot(1, v);
        chk("R11", "slot1 retained", v, 5);
        read_slot(2, v);
        chk("R11", "slot2 copied", v, 5);

        // R8 error sticky with frozen address
        do_reset();
        load_prog(128'hff000000_00000000_00000000_00000000);
        pulse_start();
        run(n);
        repeat (4) @(negedge clk);
        chk("R8", "error sticky", 32'(error), 1);
        chk("R8", "addr frozen", 32'(code_addr), 0);

        // R2 restart mid-run must empty the stack
        do_reset();
        load_prog(128'h04040404_3bb10000_00000000_00000000);
        pulse_start();
        repeat (2) @(negedge clk);
        pulse_start();
        run(n);
        chk("R2", "restart done", 32'(done), 1);
        chk("R2", "restart no error", 32'(error), 0);
        chk("R2", "restart cycles", 32'(n), 6);
        read_slot(0, v);
        chk("R2", "restart slot0", v, 1);

        // R3 address steps through the immediate byte
        do_reset();
        load_prog(128'h10053cb1_00000000_00000000_00000000);
        pulse_start();
        chk("R3", "addr at opcode", 32'(code_addr), 0);
        @(negedge clk);
        chk("R3", "addr at operand", 32'(code_addr), 1);
        @(negedge clk);
        chk("R3", "addr after push", 32'(code_addr), 2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule